// File: doc/BRIEF.md
# Four-Way Instruction Cache Controller

This block sits between an instruction fetch unit and a narrow memory bus. A fetch request carries a word address. On a hit, the controller returns one 32-bit instruction word one cycle later. On a miss, it stalls fetch and reads the whole line as a burst of 64-bit beats into a staging buffer. It then writes the line into one of four ways, which a pseudo-random selector picks. After that it repeats the lookup and answers the request.

A line is 304 bits wide. It takes five beats, and the top 16 bits of the last beat are dropped. The staged line reaches the data array in a single write. The array update is done in two steps: the tag and valid bit are written one cycle before the line data. During that cycle a lookup could report a false hit. For this reason the update sequence is driven by the controller's own state and its selector-advance strobe, never by the hit flag, and no lookup is taken while an update is in flight.

A software command can invalidate one line. The command uses the same array update address path as a refill, so it behaves like a miss: fetch stalls for the cycle in which the valid bits are cleared. After reset, the controller sweeps every set to clear the valid bits, and fetch is held off until the sweep is done.

Top module: `icache_ctrl`

## Requirements
- R1: After rst_n rises, fetch_stall stays high for exactly SETS+2 cycles (two for reset synchronization, one per set swept), while fetch_valid, mem_req and inv_done are low. After the sweep, the first fetch to any line misses.
- R2: A fetch accepted with fetch_stall low that hits raises fetch_valid in the next cycle, with the addressed word and no memory traffic.
- R3: On a miss, mem_req stays high with mem_addr = {tag, set} of the request until five mem_valid beats are taken. Beat k fills line bits [64k+63:64k], and the bits above bit 303 are discarded.
- R4: The fetch address is {tag[7:0], set[3:0], offset[3:0]}. Word offset k returns line bits [32k+31:32k]. Bits past the end of the line read as zero, so offset 9 returns the top 16 line bits zero-extended and offsets 10 to 15 return zero.
- R5: After a miss, fetch_valid rises exactly three clock edges after the edge that takes the last beat. The tag write, the data write one cycle later, and the repeated lookup each take one cycle.
- R6: The stall output is high whenever the controller is not idle, whenever an invalidate is pending, and whenever a presented fetch misses. While it is high, no response is given.
- R7: A fill replaces the contents of one way in its own set only. Lines in all other sets still hit, and the way selector changes only on the once-per-fill advance strobe.
- R8: An invalidate command (line address {tag, set}) raises inv_done for exactly one cycle, one cycle after it is presented to an idle controller, with fetch_stall high. A later fetch to that line misses, and lines in other sets still hit.
- R9: When an invalidate and a fetch are presented in the same idle cycle, the invalidate is served first and the fetch gets no response in that cycle.
- R10: Under mixed random fetches and invalidates, every response carries the correct word. A line known to be absent always misses, and a line that was the latest fill of its set and has not been invalidated since always hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_req | input | 1 | Fetch request, held until fetch_valid |
| fetch_addr | input | 16 | Word address {tag, set, offset} |
| fetch_stall | output | 1 | Controller cannot answer this cycle |
| fetch_valid | output | 1 | Response strobe |
| fetch_data | output | 32 | Instruction word |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | 12 | Line address {tag, set} |
| mem_valid | input | 1 | Beat strobe |
| mem_data | input | 64 | Beat data |
| inv_req | input | 1 | Invalidate-line command, held until inv_done |
| inv_addr | input | 12 | Line to invalidate {tag, set} |
| inv_done | output | 1 | Invalidate taken this cycle |

## Verification
The bench builds the block with its default parameters: 8-bit tags, 16 sets, four ways, a 304-bit line and 64-bit beats. With these values, a line does not fill a whole number of beats, so both the discarded half of the last beat and word offsets past the end of the line can be reached. The sweep after reset is short enough to be counted cycle by cycle. The random phase uses only four tags per set, so the sets fill up, and random replacement evicts lines while the bench tracks which lines it knows to be present or absent.

// File: rtl/icache_pkg.sv
package icache_pkg;

  typedef enum logic [2:0] {
    ST_SWEEP = 3'd0,
    ST_IDLE  = 3'd1,
    ST_FILL  = 3'd2,
    ST_TAGW  = 3'd3,
    ST_DATAW = 3'd4,
    ST_INV   = 3'd5
  } ic_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/icache_rst_sync.sv
module icache_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/icache_way_sel.sv
module icache_way_sel #(
  parameter int               SEL_W = 8,
  parameter logic [SEL_W-1:0] TAPS  = 8'hB8,
  parameter int               WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [WAY_W-1:0] way
);

  logic [SEL_W-1:0] lfsr_q;
  logic [SEL_W-1:0] lfsr_d;
  logic             fb;

  assign fb = ^(lfsr_q & TAPS);

  always_comb begin
    lfsr_d = lfsr_q;
    if (adv) lfsr_d = {lfsr_q[SEL_W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEL_W'(1);
    else        lfsr_q <= lfsr_d;
  end

  assign way = lfsr_q[WAY_W-1:0];

  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(lfsr_q));

  // R7
  sel_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

endmodule

// File: rtl/icache_stage.sv
module icache_stage #(
  parameter int BUS_W  = 64,
  parameter int LINE_W = 304,
  parameter int BEATS  = 5,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_vld,
  input  logic [BUS_W-1:0]  beat_data,
  output logic              last,
  output logic [LINE_W-1:0] line
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign last = beat_vld && (cnt_q == CNT_W'(BEATS - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (beat_vld) cnt_d = last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_slice
    localparam int SW = (g == BEATS - 1) ? (LINE_W - g * BUS_W) : BUS_W;
    logic [SW-1:0] slice_q;
    logic          take;
    assign take = beat_vld && (cnt_q == CNT_W'(g));
    always_ff @(posedge clk) begin
      if (take) slice_q <= beat_data[SW-1:0];
    end
    assign line[g*BUS_W +: SW] = slice_q;
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(BEATS));

endmodule

// File: rtl/icache_store.sv
module icache_store #(
  parameter int WAYS   = 4,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int LINE_W = 304,
  parameter int WAY_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              look_en,
  input  logic [IDX_W-1:0]  look_idx,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              hit,
  output logic [LINE_W-1:0] hit_line,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [TAG_W-1:0]  upd_tag,
  input  logic [WAY_W-1:0]  upd_way,
  input  logic              tag_we,
  input  logic              data_we,
  input  logic              inv_we,
  input  logic              sweep_we,
  input  logic [LINE_W-1:0] upd_line
);

  localparam int SETS = 1 << IDX_W;

  logic [WAYS-1:0]   match;
  logic [LINE_W-1:0] way_line [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [LINE_W-1:0] dat_q [SETS];
    logic [SETS-1:0]   val_q;
    logic              sel;
    logic              kill;

    assign sel  = (upd_way == WAY_W'(w));
    assign kill = sweep_we ||
                  (inv_we && val_q[upd_idx] && (tag_q[upd_idx] == upd_tag));

    always_ff @(posedge clk) begin
      if (tag_we && sel)  tag_q[upd_idx] <= upd_tag;
      if (data_we && sel) dat_q[upd_idx] <= upd_line;
    end

    always_ff @(posedge clk) begin
      if (kill)               val_q[upd_idx] <= 1'b0;
      else if (tag_we && sel) val_q[upd_idx] <= 1'b1;
    end

    assign match[w]    = val_q[look_idx] && (tag_q[look_idx] == look_tag);
    assign way_line[w] = dat_q[look_idx];
  end

  assign hit = |match;

  always_comb begin
    hit_line = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) hit_line = hit_line | way_line[w];
    end
  end

  // R7
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    look_en |-> $onehot0(match));

  // R6
  upd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tag_we, data_we, inv_we, sweep_we}));

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int               TAG_W    = 8,
  parameter int               IDX_W    = 4,
  parameter int               OFF_W    = 4,
  parameter int               LINE_W   = 304,
  parameter int               BUS_W    = 64,
  parameter int               INSTR_W  = 32,
  parameter int               WAYS     = 4,
  parameter int               SEL_W    = 8,
  parameter logic [SEL_W-1:0] SEL_TAPS = 8'hB8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fetch_req,
  input  logic [TAG_W+IDX_W+OFF_W-1:0]   fetch_addr,
  output logic                           fetch_stall,
  output logic                           fetch_valid,
  output logic [INSTR_W-1:0]             fetch_data,
  output logic                           mem_req,
  output logic [TAG_W+IDX_W-1:0]         mem_addr,
  input  logic                           mem_valid,
  input  logic [BUS_W-1:0]               mem_data,
  input  logic                           inv_req,
  input  logic [TAG_W+IDX_W-1:0]         inv_addr,
  output logic                           inv_done
);

  localparam int SETS  = 1 << IDX_W;
  localparam int LA_W  = TAG_W + IDX_W;
  localparam int BEATS = ceil_div(LINE_W, BUS_W);
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int PAD_W = (1 << OFF_W) * INSTR_W;

  logic              rst_i_n;
  ic_state_e         state_q, state_d;
  logic [LA_W-1:0]   addr_q, addr_d;
  logic [IDX_W-1:0]  sweep_q, sweep_d;
  logic [WAY_W-1:0]  vict_q, vict_d;
  logic              valid_q, valid_d;
  logic [INSTR_W-1:0] data_q, data_d;

  logic [OFF_W-1:0]  look_off;
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag;
  logic [LA_W-1:0]   look_line;
  logic              hit;
  logic [LINE_W-1:0] hit_line;
  logic [PAD_W-1:0]  line_pad;
  logic [INSTR_W-1:0] word;

  logic              beat_vld;
  logic              beat_last;
  logic [LINE_W-1:0] fill_line;
  logic [WAY_W-1:0]  rand_way;
  logic [WAY_W-1:0]  upd_way;
  logic [IDX_W-1:0]  upd_idx;
  logic              tag_we, data_we, inv_we, sweep_we, adv;

  assign look_off  = fetch_addr[OFF_W-1:0];
  assign look_idx  = fetch_addr[OFF_W +: IDX_W];
  assign look_tag  = fetch_addr[OFF_W+IDX_W +: TAG_W];
  assign look_line = fetch_addr[OFF_W +: LA_W];

  assign line_pad = PAD_W'(hit_line);
  assign word     = line_pad[int'(look_off)*INSTR_W +: INSTR_W];

  icache_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  icache_way_sel #(
    .SEL_W (SEL_W),
    .TAPS  (SEL_TAPS),
    .WAY_W (WAY_W)
  ) u_sel (
    .clk   (clk),
    .rst_n (rst_i_n),
    .adv   (adv),
    .way   (rand_way)
  );

  assign beat_vld = mem_valid && (state_q == ST_FILL);

  icache_stage #(
    .BUS_W  (BUS_W),
    .LINE_W (LINE_W),
    .BEATS  (BEATS),
    .CNT_W  (CNT_W)
  ) u_stage (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .beat_vld  (beat_vld),
    .beat_data (mem_data),
    .last      (beat_last),
    .line      (fill_line)
  );

  assign upd_way = (state_q == ST_TAGW)  ? rand_way : vict_q;
  assign upd_idx = (state_q == ST_SWEEP) ? sweep_q  : addr_q[IDX_W-1:0];

  icache_store #(
    .WAYS   (WAYS),
    .IDX_W  (IDX_W),
    .TAG_W  (TAG_W),
    .LINE_W (LINE_W),
    .WAY_W  (WAY_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .look_en  (state_q == ST_IDLE),
    .look_idx (look_idx),
    .look_tag (look_tag),
    .hit      (hit),
    .hit_line (hit_line),
    .upd_idx  (upd_idx),
    .upd_tag  (addr_q[LA_W-1:IDX_W]),
    .upd_way  (upd_way),
    .tag_we   (tag_we),
    .data_we  (data_we),
    .inv_we   (inv_we),
    .sweep_we (sweep_we),
    .upd_line (fill_line)
  );

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    sweep_d  = sweep_q;
    vict_d   = vict_q;
    valid_d  = 1'b0;
    data_d   = data_q;
    tag_we   = 1'b0;
    data_we  = 1'b0;
    inv_we   = 1'b0;
    sweep_we = 1'b0;
    adv      = 1'b0;
    case (state_q)
      ST_SWEEP: begin
        sweep_we = 1'b1;
        sweep_d  = sweep_q + 1'b1;
        if (sweep_q == IDX_W'(SETS - 1)) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (inv_req) begin
          addr_d  = inv_addr;
          state_d = ST_INV;
        end else if (fetch_req) begin
          if (hit) begin
            valid_d = 1'b1;
            data_d  = word;
          end else begin
            addr_d  = look_line;
            state_d = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        if (beat_last) state_d = ST_TAGW;
      end
      ST_TAGW: begin
        tag_we  = 1'b1;
        vict_d  = rand_way;
        state_d = ST_DATAW;
      end
      ST_DATAW: begin
        data_we = 1'b1;
        adv     = 1'b1;
        state_d = ST_IDLE;
      end
      ST_INV: begin
        inv_we  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_SWEEP;
      addr_q  <= '0;
      sweep_q <= '0;
      vict_q  <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      sweep_q <= sweep_d;
      vict_q  <= vict_d;
      valid_q <= valid_d;
      if (valid_d) data_q <= data_d;
    end
  end

  assign fetch_stall = (state_q != ST_IDLE) || inv_req || (fetch_req && !hit);
  assign fetch_valid = valid_q;
  assign fetch_data  = data_q;
  assign mem_req     = (state_q == ST_FILL);
  assign mem_addr    = addr_q;
  assign inv_done    = (state_q == ST_INV);

  // R2
  resp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    fetch_valid |-> $past(fetch_req && !fetch_stall));

  // R3
  fill_done_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_TAGW) |-> $past(mem_valid && mem_req));

  // R5
  tag_then_data_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    data_we |-> $past(tag_we));

  // R8
  inv_taken_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    inv_done |-> $past(inv_req));

  // R8
  inv_single_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    inv_done |=> !inv_done);

  // R9
  inv_first_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((state_q == ST_IDLE) && inv_req) |=> (inv_done && !fetch_valid));

endmodule

// File: tb/sim_icache_ctrl.sv
module sim_icache_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int TAG_W   = 8;
  localparam int IDX_W   = 4;
  localparam int OFF_W   = 4;
  localparam int LINE_W  = 304;
  localparam int BUS_W   = 64;
  localparam int INSTR_W = 32;
  localparam int WAYS    = 4;
  localparam int SETS    = 1 << IDX_W;
  localparam int BEATS   = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_req;
  logic [15:0] fetch_addr;
  logic        fetch_stall;
  logic        fetch_valid;
  logic [31:0] fetch_data;
  logic        mem_req;
  logic [11:0] mem_addr;
  logic        mem_valid;
  logic [63:0] mem_data;
  logic        inv_req;
  logic [11:0] inv_addr;
  logic        inv_done;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int bursts = 0;
  int last_beat_cyc = 0;
  logic [11:0] last_req_addr = '0;
  bit done = 1'b0;

  bit f_missed;
  int f_waits;
  int f_lat;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  icache_ctrl #(
    .TAG_W (TAG_W), .IDX_W (IDX_W), .OFF_W (OFF_W), .LINE_W (LINE_W),
    .BUS_W (BUS_W), .INSTR_W (INSTR_W), .WAYS (WAYS)
  ) u0 (
    .clk (clk), .rst_n (rst_n),
    .fetch_req (fetch_req), .fetch_addr (fetch_addr),
    .fetch_stall (fetch_stall), .fetch_valid (fetch_valid), .fetch_data (fetch_data),
    .mem_req (mem_req), .mem_addr (mem_addr), .mem_valid (mem_valid), .mem_data (mem_data),
    .inv_req (inv_req), .inv_addr (inv_addr), .inv_done (inv_done)
  );

  function automatic logic [63:0] mem_word(input logic [11:0] la, input int b);
    logic [31:0] mix;
    mix = (32'(la) * 32'h9E3779B1) ^ (32'(b) * 32'h01010101);
    return {4'h0, la, 8'(b), 8'hC3, mix};
  endfunction

  function automatic logic [31:0] exp_word(input logic [15:0] fa);
    logic [511:0] ln;
    ln = '0;
    for (int b = 0; b < BEATS; b++) ln[b*64 +: 64] = mem_word(fa[15:4], b);
    for (int i = LINE_W; i < 512; i++) ln[i] = 1'b0;
    return ln[int'(fa[3:0])*32 +: 32];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model: five beats per burst with random gaps
  initial begin
    mem_valid = 1'b0;
    mem_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        logic [11:0] a;
        a = mem_addr;
        last_req_addr = a;
        bursts++;
        for (int b = 0; b < BEATS; b++) begin
          repeat ($urandom_range(0, 2)) @(negedge clk);
          mem_valid = 1'b1;
          mem_data  = mem_word(a, b);
          @(negedge clk);
          mem_valid = 1'b0;
          last_beat_cyc = cyc;
        end
      end
    end
  end

  task automatic fetch(input logic [15:0] fa, input string req);
    int b0;
    b0 = bursts;
    fetch_req  = 1'b1;
    fetch_addr = fa;
    f_waits = 0;
    do begin
      @(negedge clk);
      f_waits++;
    end while (!fetch_valid && f_waits < 500);
    fetch_req = 1'b0;
    f_missed = (bursts != b0);
    f_lat = cyc - last_beat_cyc;
    chk({req, " response"}, 64'(fetch_valid), 64'd1);
    chk({req, " data"}, 64'(fetch_data), 64'(exp_word(fa)));
    if (f_missed) chk("R3 burst address", 64'(last_req_addr), 64'(fa[15:4]));
  endtask

  task automatic inval(input logic [11:0] la);
    int n;
    inv_req  = 1'b1;
    inv_addr = la;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!inv_done && n < 500);
    chk("R8 inv_done delay", 64'(n), 64'd1);
    chk("R8 stall during invalidate", 64'(fetch_stall), 64'd1);
    inv_req = 1'b0;
    @(negedge clk);
    chk("R8 inv_done single cycle", 64'(inv_done), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit   absent [4096];
    logic [11:0] last_fill [SETS];
    bit   last_ok [SETS];
    int   cnt;
    int   b0;

    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    fetch_req = 1'b0; fetch_addr = '0;
    inv_req = 1'b0; inv_addr = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 fetch_valid in reset", 64'(fetch_valid), 64'd0);
    chk("R1 mem_req in reset", 64'(mem_req), 64'd0);
    chk("R1 inv_done in reset", 64'(inv_done), 64'd0);
    chk("R1 stall in reset", 64'(fetch_stall), 64'd1);
    rst_n = 1'b1;
    #1;
    cnt = 0;
    while (fetch_stall && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    chk("R1 sweep stall length", 64'(cnt), 64'(SETS + 2));

    // R1/R3/R5 first fetch misses, latency from last beat
    fetch({8'h11, 4'h2, 4'h0}, "R3");
    chk("R1 first fetch misses", 64'(f_missed), 64'd1);
    chk("R5 miss latency", 64'(f_lat), 64'd3);

    // R2/R4 every offset of the line hits in one cycle
    for (int k = 0; k < 16; k++) begin
      fetch({8'h11, 4'h2, 4'(k)}, (k >= 9) ? "R4" : "R2");
      chk("R2 hit no traffic", 64'(f_missed), 64'd0);
      chk("R2 hit latency", 64'(f_waits), 64'd1);
    end

    // R7 fill touches only its own set
    for (int s = 0; s < 8; s++) fetch({8'h22, 4'(s), 4'(s)}, "R7");
    fetch({8'h33, 4'd3, 4'd1}, "R7");
    chk("R7 new tag misses", 64'(f_missed), 64'd1);
    for (int s = 0; s < 8; s++) begin
      if (s != 3) begin
        fetch({8'h22, 4'(s), 4'd8}, "R7");
        chk("R7 other set still hits", 64'(f_missed), 64'd0);
      end
    end

    // R8 invalidate one line
    inval({8'h22, 4'd5});
    fetch({8'h22, 4'd5, 4'd2}, "R8");
    chk("R8 invalidated line misses", 64'(f_missed), 64'd1);
    fetch({8'h22, 4'd6, 4'd2}, "R8");
    chk("R8 other set hits", 64'(f_missed), 64'd0);

    // R9 invalidate wins over a same-cycle fetch
    b0 = bursts;
    fetch_req = 1'b1; fetch_addr = {8'h22, 4'd7, 4'd4};
    inv_req = 1'b1; inv_addr = {8'h22, 4'd7};
    @(negedge clk);
    chk("R9 invalidate served first", 64'(inv_done), 64'd1);
    chk("R9 no fetch response", 64'(fetch_valid), 64'd0);
    chk("R6 stall while invalidating", 64'(fetch_stall), 64'd1);
    inv_req = 1'b0;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!fetch_valid && cnt < 500);
    fetch_req = 1'b0;
    chk("R9 fetch after invalidate misses", 64'(bursts != b0), 64'd1);
    chk("R9 fetch data", 64'(fetch_data), 64'(exp_word({8'h22, 4'd7, 4'd4})));

    // R10 random mix
    for (int i = 0; i < 4096; i++) absent[i] = 1'b1;
    for (int s = 0; s < SETS; s++) begin last_fill[s] = '0; last_ok[s] = 1'b0; end
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  tg;
      logic [3:0]  st;
      logic [3:0]  of;
      logic [11:0] la;
      int r;
      r  = $urandom_range(0, 9);
      tg = 8'h40 + 8'($urandom_range(0, 3));
      st = 4'($urandom_range(0, 15));
      of = 4'($urandom_range(0, 15));
      la = {tg, st};
      if (r < 2) begin
        inval(la);
        absent[la] = 1'b1;
        if (last_fill[st] == la) last_ok[st] = 1'b0;
      end else begin
        bit exp_miss;
        bit exp_hit;
        exp_miss = absent[la];
        exp_hit  = last_ok[st] && (last_fill[st] == la);
        fetch({la, of}, "R10");
        if (exp_miss) chk("R10 absent line misses", 64'(f_missed), 64'd1);
        if (exp_hit) begin
          chk("R10 latest fill hits", 64'(f_missed), 64'd0);
          chk("R10 hit latency", 64'(f_waits), 64'd1);
        end
        if (f_missed) begin
          chk("R10 miss latency", 64'(f_lat), 64'd3);
          last_fill[st] = la;
          last_ok[st]   = 1'b1;
          absent[la]    = 1'b0;
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule